// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the software-visible control store of a simple Ethernet MAC. A host reaches it through a synchronous port made of an 8-bit register offset, a write strobe with 16-bit write data, and a read strobe. Read data is registered and appears on the clock edge that follows the read strobe. The bank holds configuration words for the transmit and receive paths, the interrupt event mask, the FIFO settings, preset values for the collision and receive error counters, the random seed, the three station address words and the four multicast hash words. It drives all of these to the datapath as decoded outputs.

Two registers clear themselves when they are read: the global event status and the 8-bit peak-attempts value. Status events enter through a side input and are OR-ed into the status word. The peak-attempts value is loaded through a side input. An interrupt output is asserted while any status bit is set whose mask bit is clear. Software resets of the transmitter and the receiver are requested by writing particular values to two registers, and each request produces a one-cycle pulse.

Offset map (hex): 00 transmit interface control, 08 event mask, 0C global status, 10 transmit FIFO control, 14 transmit FIFO threshold, 18 receive FIFO control, 1C transmit soft reset, 20 receive soft reset, 24 transmit config, 28 receive config, 2C peak attempts, 30 normal collisions, 34 net collisions, 38 excessive collisions, 3C late collisions, 40 random seed, 44/48/4C/50/54 receive frame/length/alignment/FCS/code-violation counters, 60/70/80 station address, C0/D0/E0/F0 hash table.

Top module: `emac_regbank`

## Requirements
- R1: After reset the event mask reads 0xFFFF, the global status reads 0, the transmit soft-reset register reads 1, and irq is 0.
- R2: The transmit interface control, transmit config, receive config, event mask and the normal, excessive and late collision counters read back the last value written to them. Read data appears one cycle after the read strobe.
- R3: A read of the global status (offset 0x0C) returns the accumulated stat_set bits and clears the register. A second read returns 0. A write to this offset has no effect.
- R4: A stat_set bit that arrives in the same cycle as a status read is not returned by that read. It stays pending and is returned by the next read.
- R5: A read of peak attempts (offset 0x2C) returns the 8-bit value last loaded through peak_ld, zero-extended, and clears it to 0.
- R6: A write to a FIFO control register (transmit 0x10, receive 0x18) sets the FIFO enable from data bit 0. It sets the FIFO size in bytes to (bits 8:1 + 1) × 128.
- R7: Writing exactly 1 to the transmit soft-reset register (0x1C) makes it read 0 and pulses tx_rst_pulse for one cycle. Any other value written is stored and produces no pulse.
- R8: Writing 0 to the receive soft-reset register (0x20) pulses rx_rst_pulse for one cycle. A nonzero write produces no pulse.
- R9: irq is 1 exactly when some status bit is set whose event mask bit is 0.
- R10: A write to a station address offset stores the word at index 8 minus offset bits 7:4. Index k drives station_addr bits 16k+15:16k.
- R11: A write to a hash offset stores the word at index offset bits 5:4. Index k drives hash_tab bits 16k+15:16k.
- R12: The net collision counter, random seed, FIFO threshold and receive error counters are write-only. Their values reach the outputs, and reads of them return 0.
- R13: A read of an unimplemented offset returns 0. A write to one changes no readable register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data, valid the cycle after reg_rd |
| stat_set | input | 16 | Status event bits to OR into global status |
| peak_ld | input | 1 | Load strobe for peak attempts |
| peak_ld_val | input | 8 | Value loaded into peak attempts |
| irq | output | 1 | Unmasked status pending |
| tx_rst_pulse | output | 1 | Transmit soft-reset pulse |
| rx_rst_pulse | output | 1 | Receive soft-reset pulse |
| tx_fifo_en | output | 1 | Transmit FIFO enable |
| tx_fifo_bytes | output | 16 | Transmit FIFO size in bytes |
| rx_fifo_en | output | 1 | Receive FIFO enable |
| rx_fifo_bytes | output | 16 | Receive FIFO size in bytes |
| tx_fifo_thresh | output | 16 | Transmit FIFO threshold |
| rng_seed | output | 16 | Backoff random seed |
| net_coll_cnt | output | 16 | Net collision counter preset |
| rx_err_cnt | output | 80 | Receive counters: frame, length, alignment, FCS, code violation from LSB word up |
| station_addr | output | 48 | Station address words |
| hash_tab | output | 64 | Multicast hash words |

## Verification
The hardest case to create is a status event that coincides with the clearing read. This is the R4 case, and it happens only when stat_set and the read strobe fall in the same clock. The bench drives both in one cycle from a single task. It then reads the status twice, and expects the old bits on the first read and the new event on the second. The clear-on-read of peak attempts needs a similar order. The value is loaded, read once to get it, and read again to show that it has cleared. The pulse outputs last one cycle, so the bench samples them in the cycle that follows the write, inside the write task.

// File: rtl/emac_regbank_pkg.sv
package emac_regbank_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 8;
    localparam int PEAK_W       = 8;
    localparam int FIFO_FIELD_W = 8;
    localparam int FIFO_SHIFT   = 7;
    localparam int FIFO_BYTES_W = FIFO_FIELD_W + 1 + FIFO_SHIFT;
    localparam int N_STA        = 3;
    localparam int N_HASH       = 4;
    localparam int N_RXCNT      = 5;
    localparam int STA_BASE     = 8;

    localparam logic [ADDR_W-1:0] OFS_XIFC    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EVMASK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_GSTAT   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXFIFO  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TXTHR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_RXFIFO  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TXRST   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RXRST   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_TXCFG   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RXCFG   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_PEAK    = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_NCOLL   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_NTCOLL  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_EXCOLL  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_LTCOLL  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_SEED    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RXCNT0  = 8'h44;

    typedef struct packed {
        logic xifc;
        logic evmask;
        logic gstat;
        logic txfifo;
        logic txthr;
        logic rxfifo;
        logic txrst;
        logic rxrst;
        logic txcfg;
        logic rxcfg;
        logic peak;
        logic ncoll;
        logic ntcoll;
        logic excoll;
        logic ltcoll;
        logic seed;
        logic [N_RXCNT-1:0] rxcnt;
        logic sta;
        logic hash;
    } reg_sel_t;

    typedef struct packed {
        logic                    en;
        logic [FIFO_BYTES_W-1:0] bytes;
    } fifo_cfg_t;

    function automatic fifo_cfg_t fifo_decode(input logic [DATA_W-1:0] w);
        fifo_cfg_t c;
        c.en    = w[0];
        c.bytes = ({{(FIFO_BYTES_W-FIFO_FIELD_W){1'b0}}, w[FIFO_FIELD_W:1]}
                   + FIFO_BYTES_W'(1)) << FIFO_SHIFT;
        return c;
    endfunction

    function automatic int sta_index(input logic [ADDR_W-1:0] a);
        return STA_BASE - int'(a[7:4]);
    endfunction

    function automatic int hash_index(input logic [ADDR_W-1:0] a);
        return int'(a[5:4]);
    endfunction

endpackage

// File: rtl/emac_regbank_decode.sv
module emac_regbank_decode
    import emac_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel = '0;
        case (addr)
            OFS_XIFC:   sel.xifc   = 1'b1;
            OFS_EVMASK: sel.evmask = 1'b1;
            OFS_GSTAT:  sel.gstat  = 1'b1;
            OFS_TXFIFO: sel.txfifo = 1'b1;
            OFS_TXTHR:  sel.txthr  = 1'b1;
            OFS_RXFIFO: sel.rxfifo = 1'b1;
            OFS_TXRST:  sel.txrst  = 1'b1;
            OFS_RXRST:  sel.rxrst  = 1'b1;
            OFS_TXCFG:  sel.txcfg  = 1'b1;
            OFS_RXCFG:  sel.rxcfg  = 1'b1;
            OFS_PEAK:   sel.peak   = 1'b1;
            OFS_NCOLL:  sel.ncoll  = 1'b1;
            OFS_NTCOLL: sel.ntcoll = 1'b1;
            OFS_EXCOLL: sel.excoll = 1'b1;
            OFS_LTCOLL: sel.ltcoll = 1'b1;
            OFS_SEED:   sel.seed   = 1'b1;
            default: begin
                for (int k = 0; k < N_RXCNT; k++) begin
                    if (addr == OFS_RXCNT0 + ADDR_W'(4 * k)) sel.rxcnt[k] = 1'b1;
                end
                if (addr[3:0] == 4'h0) begin
                    if (addr[7:4] >= 4'(STA_BASE - N_STA + 1) && addr[7:4] <= 4'(STA_BASE))
                        sel.sta = 1'b1;
                    if (addr[7:6] == 2'b11)
                        sel.hash = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/emac_regbank_rclr.sv
module emac_regbank_rclr #(
    parameter int W     = 16,
    parameter bit ACCUM = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_hit,
    input  logic         set_en,
    input  logic [W-1:0] set_val,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    generate
        if (ACCUM) begin : g_accum
            logic [W-1:0] eff;
            always_comb begin
                eff    = set_en ? set_val : '0;
                q_next = rd_hit ? eff : (q | eff);
            end
        end else begin : g_load
            always_comb begin
                if (set_en)      q_next = set_val;
                else if (rd_hit) q_next = '0;
                else             q_next = q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end
endmodule

// File: rtl/emac_regbank_filt.sv
module emac_regbank_filt
    import emac_regbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic                     sta_hit,
    input  logic                     hash_hit,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [N_STA*DATA_W-1:0]  station_addr,
    output logic [N_HASH*DATA_W-1:0] hash_tab
);
    generate
        for (genvar k = 0; k < N_STA; k++) begin : g_sta
            logic [DATA_W-1:0] w;
            always_ff @(posedge clk) begin
                if (rst) w <= '0;
                else if (wr && sta_hit && sta_index(addr) == k) w <= wdata;
            end
            assign station_addr[k*DATA_W +: DATA_W] = w;
        end
        for (genvar k = 0; k < N_HASH; k++) begin : g_hash
            logic [DATA_W-1:0] w;
            always_ff @(posedge clk) begin
                if (rst) w <= '0;
                else if (wr && hash_hit && hash_index(addr) == k) w <= wdata;
            end
            assign hash_tab[k*DATA_W +: DATA_W] = w;
        end
    endgenerate
endmodule

// File: rtl/emac_regbank.sv
module emac_regbank
    import emac_regbank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic                          reg_rd,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [DATA_W-1:0]             stat_set,
    input  logic                          peak_ld,
    input  logic [PEAK_W-1:0]             peak_ld_val,
    output logic                          irq,
    output logic                          tx_rst_pulse,
    output logic                          rx_rst_pulse,
    output logic                          tx_fifo_en,
    output logic [FIFO_BYTES_W-1:0]       tx_fifo_bytes,
    output logic                          rx_fifo_en,
    output logic [FIFO_BYTES_W-1:0]       rx_fifo_bytes,
    output logic [DATA_W-1:0]             tx_fifo_thresh,
    output logic [DATA_W-1:0]             rng_seed,
    output logic [DATA_W-1:0]             net_coll_cnt,
    output logic [N_RXCNT*DATA_W-1:0]     rx_err_cnt,
    output logic [N_STA*DATA_W-1:0]       station_addr,
    output logic [N_HASH*DATA_W-1:0]      hash_tab
);
    reg_sel_t          sel;
    logic              rd_stat, rd_peak;
    logic [DATA_W-1:0] stat_q;
    logic [PEAK_W-1:0] peak_q;
    logic [DATA_W-1:0] xifc_q, mask_q, txcfg_q, rxcfg_q, txrst_q;
    logic [DATA_W-1:0] ncoll_q, excoll_q, ltcoll_q;
    fifo_cfg_t         txfifo_q, rxfifo_q;
    logic [DATA_W-1:0] rd_mux;

    emac_regbank_decode u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign rd_stat = reg_rd && sel.gstat;
    assign rd_peak = reg_rd && sel.peak;

    emac_regbank_rclr #(.W(DATA_W), .ACCUM(1'b1)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .rd_hit  (rd_stat),
        .set_en  (1'b1),
        .set_val (stat_set),
        .q       (stat_q)
    );

    emac_regbank_rclr #(.W(PEAK_W), .ACCUM(1'b0)) u_peak (
        .clk     (clk),
        .rst     (rst),
        .rd_hit  (rd_peak),
        .set_en  (peak_ld),
        .set_val (peak_ld_val),
        .q       (peak_q)
    );

    emac_regbank_filt u_filt (
        .clk          (clk),
        .rst          (rst),
        .wr           (reg_wr),
        .sta_hit      (sel.sta),
        .hash_hit     (sel.hash),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .station_addr (station_addr),
        .hash_tab     (hash_tab)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xifc_q         <= '0;
            mask_q         <= '1;
            txcfg_q        <= '0;
            rxcfg_q        <= '0;
            txrst_q        <= DATA_W'(1);
            ncoll_q        <= '0;
            excoll_q       <= '0;
            ltcoll_q       <= '0;
            txfifo_q       <= '0;
            rxfifo_q       <= '0;
            tx_fifo_thresh <= '0;
            rng_seed       <= '0;
            net_coll_cnt   <= '0;
            tx_rst_pulse   <= 1'b0;
            rx_rst_pulse   <= 1'b0;
        end else begin
            tx_rst_pulse <= 1'b0;
            rx_rst_pulse <= 1'b0;
            if (reg_wr) begin
                if (sel.xifc)   xifc_q         <= reg_wdata;
                if (sel.evmask) mask_q         <= reg_wdata;
                if (sel.txcfg)  txcfg_q        <= reg_wdata;
                if (sel.rxcfg)  rxcfg_q        <= reg_wdata;
                if (sel.ncoll)  ncoll_q        <= reg_wdata;
                if (sel.excoll) excoll_q       <= reg_wdata;
                if (sel.ltcoll) ltcoll_q       <= reg_wdata;
                if (sel.ntcoll) net_coll_cnt   <= reg_wdata;
                if (sel.seed)   rng_seed       <= reg_wdata;
                if (sel.txthr)  tx_fifo_thresh <= reg_wdata;
                if (sel.txfifo) txfifo_q       <= fifo_decode(reg_wdata);
                if (sel.rxfifo) rxfifo_q       <= fifo_decode(reg_wdata);
                if (sel.txrst) begin
                    if (reg_wdata == DATA_W'(1)) begin
                        txrst_q      <= '0;
                        tx_rst_pulse <= 1'b1;
                    end else begin
                        txrst_q      <= reg_wdata;
                    end
                end
                if (sel.rxrst && reg_wdata == '0) rx_rst_pulse <= 1'b1;
            end
        end
    end

    generate
        for (genvar k = 0; k < N_RXCNT; k++) begin : g_rxcnt
            logic [DATA_W-1:0] c;
            always_ff @(posedge clk) begin
                if (rst) c <= '0;
                else if (reg_wr && sel.rxcnt[k]) c <= reg_wdata;
            end
            assign rx_err_cnt[k*DATA_W +: DATA_W] = c;
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (sel.xifc)   rd_mux = xifc_q;
        if (sel.evmask) rd_mux = mask_q;
        if (sel.gstat)  rd_mux = stat_q;
        if (sel.txrst)  rd_mux = txrst_q;
        if (sel.txcfg)  rd_mux = txcfg_q;
        if (sel.rxcfg)  rd_mux = rxcfg_q;
        if (sel.peak)   rd_mux = DATA_W'(peak_q);
        if (sel.ncoll)  rd_mux = ncoll_q;
        if (sel.excoll) rd_mux = excoll_q;
        if (sel.ltcoll) rd_mux = ltcoll_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end

    assign irq           = |(stat_q & ~mask_q);
    assign tx_fifo_en    = txfifo_q.en;
    assign tx_fifo_bytes = txfifo_q.bytes;
    assign rx_fifo_en    = rxfifo_q.en;
    assign rx_fifo_bytes = rxfifo_q.bytes;
endmodule

// File: rtl/emac_regbank_chk.sv
module emac_regbank_chk
    import emac_regbank_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic                    reg_wr,
    input logic [DATA_W-1:0]       reg_wdata,
    input logic                    reg_rd,
    input logic [DATA_W-1:0]       reg_rdata,
    input logic                    irq,
    input logic                    tx_rst_pulse,
    input logic                    rx_rst_pulse,
    input logic [FIFO_BYTES_W-1:0] tx_fifo_bytes,
    input logic [DATA_W-1:0]       stat_q,
    input logic [DATA_W-1:0]       mask_q,
    input reg_sel_t                sel
);
    assert_stat_read_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_GSTAT) |=> reg_rdata == $past(stat_q))
        else $error("status read value");

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq)
        else $error("irq while fully masked");

    assert_tx_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_TXRST && reg_wdata == DATA_W'(1)) |=> tx_rst_pulse)
        else $error("tx soft reset pulse missing");

    assert_rx_pulse_src_R8: assert property (@(posedge clk) disable iff (rst)
        rx_rst_pulse |-> $past(reg_wr && reg_addr == OFS_RXRST && reg_wdata == '0))
        else $error("spurious rx reset pulse");

    assert_fifo_size_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_TXFIFO) |=>
        tx_fifo_bytes == (FIFO_BYTES_W'($past(reg_wdata[FIFO_FIELD_W:1])) + FIFO_BYTES_W'(1)) << FIFO_SHIFT)
        else $error("fifo size decode");

    assert_sel_onehot_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel))
        else $error("decode overlap");
endmodule

bind emac_regbank emac_regbank_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rd        (reg_rd),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .tx_rst_pulse  (tx_rst_pulse),
    .rx_rst_pulse  (rx_rst_pulse),
    .tx_fifo_bytes (tx_fifo_bytes),
    .stat_q        (stat_q),
    .mask_q        (mask_q),
    .sel           (sel)
);

// File: tb/emac_regbank_tb.sv
module emac_regbank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic [15:0] stat_set = '0;
    logic        peak_ld = 1'b0;
    logic [7:0]  peak_ld_val = '0;
    logic        irq, tx_rst_pulse, rx_rst_pulse, tx_fifo_en, rx_fifo_en;
    logic [15:0] tx_fifo_bytes, rx_fifo_bytes, tx_fifo_thresh, rng_seed, net_coll_cnt;
    logic [79:0] rx_err_cnt;
    logic [47:0] station_addr;
    logic [63:0] hash_tab;

    int n_checks = 0;
    int n_fail   = 0;
    logic seen_tx_pulse, seen_rx_pulse;

    always #2 clk = ~clk;

    emac_regbank u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .stat_set(stat_set), .peak_ld(peak_ld),
        .peak_ld_val(peak_ld_val), .irq(irq), .tx_rst_pulse(tx_rst_pulse),
        .rx_rst_pulse(rx_rst_pulse), .tx_fifo_en(tx_fifo_en), .tx_fifo_bytes(tx_fifo_bytes),
        .rx_fifo_en(rx_fifo_en), .rx_fifo_bytes(rx_fifo_bytes), .tx_fifo_thresh(tx_fifo_thresh),
        .rng_seed(rng_seed), .net_coll_cnt(net_coll_cnt), .rx_err_cnt(rx_err_cnt),
        .station_addr(station_addr), .hash_tab(hash_tab)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        seen_tx_pulse = tx_rst_pulse;
        seen_rx_pulse = rx_rst_pulse;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse_stat(input logic [15:0] b);
        @(negedge clk);
        stat_set = b;
        @(negedge clk);
        stat_set = '0;
    endtask

    task automatic t_reset;
        check("R1 irq", irq, 0);
        rd_chk("R1 mask", 8'h08, 16'hFFFF);
        rd_chk("R1 status", 8'h0C, 16'h0000);
        rd_chk("R1 txrst", 8'h1C, 16'h0001);
    endtask

    task automatic t_readback;
        wr(8'h00, 16'h1234); wr(8'h24, 16'hBEEF); wr(8'h28, 16'h0F0F);
        wr(8'h30, 16'h0011); wr(8'h38, 16'h0022); wr(8'h3C, 16'h0033);
        rd_chk("R2 xifc", 8'h00, 16'h1234);
        rd_chk("R2 txcfg", 8'h24, 16'hBEEF);
        rd_chk("R2 rxcfg", 8'h28, 16'h0F0F);
        rd_chk("R2 ncoll", 8'h30, 16'h0011);
        rd_chk("R2 excoll", 8'h38, 16'h0022);
        rd_chk("R2 ltcoll", 8'h3C, 16'h0033);
    endtask

    task automatic t_status_irq;
        pulse_stat(16'h0005);
        check("R9 masked irq", irq, 0);
        wr(8'h08, 16'hFFFB);
        check("R9 unmasked irq", irq, 1);
        wr(8'h0C, 16'h0000);
        check("R3 write ignored", irq, 1);
        rd_chk("R3 first read", 8'h0C, 16'h0005);
        check("R9 irq after clear", irq, 0);
        rd_chk("R3 second read", 8'h0C, 16'h0000);
        wr(8'h08, 16'hFFFF);
    endtask

    task automatic t_status_race;
        logic [15:0] d;
        pulse_stat(16'h0010);
        @(negedge clk);
        reg_addr = 8'h0C; reg_rd = 1'b1; stat_set = 16'h0002;
        @(negedge clk);
        reg_rd = 1'b0; stat_set = '0;
        d = reg_rdata;
        check("R4 read returns old", d, 16'h0010);
        rd_chk("R4 pending next read", 8'h0C, 16'h0002);
        rd_chk("R4 then empty", 8'h0C, 16'h0000);
    endtask

    task automatic t_peak;
        @(negedge clk);
        peak_ld = 1'b1; peak_ld_val = 8'hA5;
        @(negedge clk);
        peak_ld = 1'b0;
        rd_chk("R5 peak value", 8'h2C, 16'h00A5);
        rd_chk("R5 peak cleared", 8'h2C, 16'h0000);
    endtask

    task automatic t_fifo;
        wr(8'h10, 16'h0003);
        check("R6 tx en", tx_fifo_en, 1);
        check("R6 tx bytes", tx_fifo_bytes, 16'd256);
        wr(8'h10, 16'h01FE);
        check("R6 tx en off", tx_fifo_en, 0);
        check("R6 tx bytes max", tx_fifo_bytes, 16'd32768);
        wr(8'h18, 16'h0001);
        check("R6 rx en", rx_fifo_en, 1);
        check("R6 rx bytes min", rx_fifo_bytes, 16'd128);
    endtask

    task automatic t_softrst;
        wr(8'h1C, 16'h0001);
        check("R7 tx pulse", seen_tx_pulse, 1);
        rd_chk("R7 tx acked", 8'h1C, 16'h0000);
        wr(8'h1C, 16'h0005);
        check("R7 no pulse", seen_tx_pulse, 0);
        rd_chk("R7 stored", 8'h1C, 16'h0005);
        wr(8'h20, 16'h0000);
        check("R8 rx pulse", seen_rx_pulse, 1);
        wr(8'h20, 16'h0003);
        check("R8 rx no pulse", seen_rx_pulse, 0);
    endtask

    task automatic t_filter;
        wr(8'h60, 16'hAAAA); wr(8'h70, 16'hBBBB); wr(8'h80, 16'hCCCC);
        check("R10 station", station_addr, 48'hAAAA_BBBB_CCCC);
        wr(8'hC0, 16'h1111); wr(8'hD0, 16'h2222); wr(8'hE0, 16'h3333); wr(8'hF0, 16'h4444);
        check("R11 hash", hash_tab, 64'h4444_3333_2222_1111);
    endtask

    task automatic t_writeonly;
        wr(8'h34, 16'h0101); wr(8'h40, 16'h0202); wr(8'h14, 16'h0303);
        wr(8'h44, 16'h0A0A); wr(8'h54, 16'h0E0E);
        check("R12 netcoll out", net_coll_cnt, 16'h0101);
        check("R12 seed out", rng_seed, 16'h0202);
        check("R12 thresh out", tx_fifo_thresh, 16'h0303);
        check("R12 rxcnt out", rx_err_cnt, 80'h0E0E_0000_0000_0000_0A0A);
        rd_chk("R12 netcoll read", 8'h34, 16'h0000);
        rd_chk("R12 seed read", 8'h40, 16'h0000);
        rd_chk("R12 rxcnt read", 8'h44, 16'h0000);
    endtask

    task automatic t_unimpl;
        wr(8'h5C, 16'hDEAD);
        wr(8'h90, 16'hDEAD);
        rd_chk("R13 unimpl read", 8'h5C, 16'h0000);
        rd_chk("R13 xifc kept", 8'h00, 16'h1234);
        check("R13 station kept", station_addr, 48'hAAAA_BBBB_CCCC);
        check("R13 hash kept", hash_tab, 64'h4444_3333_2222_1111);
        check("R13 irq kept", irq, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_status_irq();
        t_status_race();
        t_peak();
        t_fifo();
        t_softrst();
        t_filter();
        t_writeonly();
        t_unimpl();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule